// File: doc/BRIEF.md
# TDM Time-Slot Port with Signalling-Frame Detect

This block is the serial time-division-multiplexed front end of one voice channel. It runs on a fast system clock and watches a slower TDM bit clock, an 8 kHz frame sync and a serial data line. All three are resynchronised to the system clock. The block counts bit positions from each frame sync. During the programmed input slot it shifts in one word and hands it to the datapath. During the programmed output slot it drives one word back onto the line. At all other times its output enable stays low, so the pad sits in high impedance.

Slot width comes from the coding direction. An encoding channel takes 8-bit PCM slots in and drives 4-bit slots out. A decoding channel does the reverse. In pass-through mode the input and output share one width, chosen by the direction bit. A frame sync that stays high for two bit clocks marks a signalling frame. The block raises a flag for the datapath, and when the 32 kbps algorithm is selected it reports 24 kbps as the algorithm in effect. The whole channel configuration is latched once per frame, at the frame start.

Top module: `tdm_slot_port`

## Requirements
- R1: After reset, `tdm_doe`, `rx_valid` and `sig_frame` are 0 and `alg_eff` is 0. The output is never enabled before the first frame sync is seen.
- R2: A frame starts at the bit-clock rising edge where the frame sync is seen high after it was low at the previous rising edge; that bit is bit 0. Slot k of width w covers bits k*w to k*w+w-1, most significant bit first. Input bits are taken on falling edges, and the output changes after rising edges.
- R3: With `cfg_compress`=1 and `cfg_bypass`=0, input slots are 8 bits wide and the whole byte appears on `rx_word`, with one `rx_valid` pulse after its last bit. Output slots are 4 bits wide and carry `tx_word[3:0]`.
- R4: With `cfg_compress`=0 and `cfg_bypass`=0, input slots are 4 bits wide and `rx_word` = {4'b0, nibble}. Output slots are 8 bits wide and carry `tx_word`.
- R5: With `cfg_bypass`=1, both sides use 8-bit slots when `cfg_compress`=1 and 4-bit slots when it is 0. The output carries the word captured in the previous frame, and `tx_word` is ignored.
- R6: The output word is loaded at the frame start. A change of `tx_word` later in the frame does not alter that frame's output.
- R7: With `cfg_idle`=1 latched, `tdm_doe` stays 0 for the whole frame.
- R8: `tdm_doe` is 1 on exactly the bits of the programmed output slot. A slot index at or beyond (frame bits / slot width) is never driven, so an 8-bit slot 40 is never driven while a 4-bit slot 40 is.
- R9: A frame has 256 bit positions for either companding law (both are parameters). Without a new sync the counter stops at the end of the frame, and no slot is matched again until the next sync.
- R10: If the frame sync is still high at the second rising edge of a frame, `sig_frame` is 1 from then until the next frame start. A sync that is one clock wide leaves it at 0.
- R11: The algorithm code is 0 for 32 kbps, 1 for 24 kbps, 2 for 16 kbps and 3 reserved. `alg_eff` is 1 when `sig_frame`=1 and the latched code is 0. Otherwise it equals the latched code.
- R12: All `cfg_*` inputs are latched at the frame start. A change made in the middle of a frame takes effect from the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tdm_clk | input | 1 | TDM bit clock, asynchronous and much slower than clk |
| tdm_fsync | input | 1 | Frame sync |
| tdm_din | input | 1 | Serial data in |
| cfg_idle | input | 1 | Disable the channel output |
| cfg_bypass | input | 1 | Pass the captured word through unchanged |
| cfg_compress | input | 1 | 1 = encode direction, 0 = decode direction |
| cfg_mulaw | input | 1 | Companding law; selects the frame length parameter |
| cfg_alg | input | 2 | Algorithm code |
| cfg_in_slot | input | 6 | Input slot index |
| cfg_out_slot | input | 6 | Output slot index |
| tx_word | input | 8 | Word from the datapath for the output slot |
| tdm_dout | output | 1 | Serial data out, valid while tdm_doe is 1 |
| tdm_doe | output | 1 | Output enable; 0 means the pad is high impedance |
| rx_word | output | 8 | Last captured input word |
| rx_valid | output | 1 | One-cycle pulse when rx_word is updated |
| sig_frame | output | 1 | The current frame is a signalling frame |
| alg_eff | output | 2 | Algorithm in effect for this frame |

## Verification
A table of configurations covers encode, decode and pass-through at both widths, with slots at index 0, in the middle and at the last index. Each configuration places a known word in the input slot, then checks the captured word and the exact bit positions and values of the following frame's output. The output check tells a slot misplaced by one, a swapped width or a reversed bit order apart from a correct result. Directed frames then cover: a one-clock against a two-clock sync with each algorithm code; an overlong frame, to separate a stopping counter from a wrapping one; slot 40 at both widths; an idle channel; and slot and data changes made in the middle of a frame.

// File: rtl/tsa_pkg.sv
package tsa_pkg;

    localparam int SLOT_W     = 6;
    localparam int WORD_W     = 8;
    localparam int NIBBLE_W   = 4;

    typedef enum logic [1:0] {
        ALG_R32 = 2'd0,
        ALG_R24 = 2'd1,
        ALG_R16 = 2'd2,
        ALG_RSV = 2'd3
    } alg_e;

    typedef struct packed {
        logic              idle;
        logic              bypass;
        logic              compress;
        logic              mulaw;
        alg_e              alg;
        logic [SLOT_W-1:0] in_slot;
        logic [SLOT_W-1:0] out_slot;
    } chan_cfg_t;

    localparam chan_cfg_t CFG_RESET = '{
        idle:     1'b1,
        bypass:   1'b0,
        compress: 1'b0,
        mulaw:    1'b0,
        alg:      ALG_R32,
        in_slot:  '0,
        out_slot: '0
    };

    // Input slots are wide whenever the channel encodes.
    function automatic logic in_is_wide(input logic compress);
        return compress;
    endfunction

    // Output follows the input width in pass-through, the opposite width otherwise.
    function automatic logic out_is_wide(input logic compress, input logic bypass);
        return bypass ? compress : !compress;
    endfunction

    // A signalling frame downgrades the 32 kbps choice to 24 kbps.
    function automatic alg_e eff_alg(input alg_e sel, input logic sig);
        return (sig && sel == ALG_R32) ? ALG_R24 : sel;
    endfunction

endpackage

// File: rtl/tsa_sync_edge.sv
module tsa_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tdm_clk,
    input  logic tdm_fsync,
    input  logic tdm_din,
    output logic rise,
    output logic fall,
    output logic fs_s,
    output logic din_s
);
    localparam int LANES = 3;

    logic [LANES-1:0] stg [STAGES];
    logic             clk_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
            clk_d <= 1'b0;
        end else begin
            stg[0] <= {tdm_clk, tdm_fsync, tdm_din};
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
            clk_d <= stg[STAGES-1][2];
        end
    end

    assign rise  =  stg[STAGES-1][2] & ~clk_d;
    assign fall  = ~stg[STAGES-1][2] &  clk_d;
    assign fs_s  =  stg[STAGES-1][1];
    assign din_s =  stg[STAGES-1][0];

endmodule

// File: rtl/tsa_frame_ctr.sv
module tsa_frame_ctr
    import tsa_pkg::*;
#(
    parameter int FRAME_MU = 256,
    parameter int FRAME_A  = 256,
    parameter int POS_W    = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rise,
    input  logic             fs_s,
    input  chan_cfg_t        cfg_in,
    output logic [POS_W-1:0] bitpos,
    output logic             in_range,
    output logic             frame_start,
    output logic             sig_frame,
    output chan_cfg_t        act
);
    localparam int FRAME_MAX = (FRAME_MU > FRAME_A) ? FRAME_MU : FRAME_A;

    logic             fs_prev;
    logic [POS_W-1:0] limit;

    assign limit    = act.mulaw ? POS_W'(FRAME_MU) : POS_W'(FRAME_A);
    assign in_range = bitpos < limit;

    always_ff @(posedge clk) begin
        if (rst) begin
            bitpos      <= POS_W'(FRAME_MAX);
            fs_prev     <= 1'b0;
            sig_frame   <= 1'b0;
            frame_start <= 1'b0;
            act         <= CFG_RESET;
        end else begin
            frame_start <= 1'b0;
            if (rise) begin
                fs_prev <= fs_s;
                if (fs_s && !fs_prev) begin
                    bitpos      <= '0;
                    act         <= cfg_in;
                    sig_frame   <= 1'b0;
                    frame_start <= 1'b1;
                end else begin
                    if (in_range) bitpos <= bitpos + 1'b1;
                    if (fs_s && fs_prev && bitpos == '0) sig_frame <= 1'b1;
                end
            end
        end
    end

    // R2: a new frame always begins at bit position zero
    a_r2_start_at_zero: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> bitpos == '0);

    // R10: the signalling flag is cleared at each frame start
    a_r10_sig_clear: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> !sig_frame);

    // R9: past the end of the frame the counter stays put
    a_r9_saturate: assert property (@(posedge clk) disable iff (rst)
        (rise && !in_range && !fs_s) |=> $stable(bitpos));

    // R12: configuration only moves on a bit-clock edge
    a_r12_cfg_hold: assert property (@(posedge clk) disable iff (rst)
        !rise |=> $stable(act));

endmodule

// File: rtl/tsa_rx.sv
module tsa_rx
    import tsa_pkg::*;
#(
    parameter int POS_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fall,
    input  logic              din_s,
    input  logic [POS_W-1:0]  bitpos,
    input  logic              in_range,
    input  logic              compress,
    input  logic [SLOT_W-1:0] in_slot,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_valid
);
    logic              wide;
    logic [POS_W-1:0]  slot_idx;
    logic [2:0]        offset;
    logic [2:0]        last_off;
    logic              hit;
    logic [WORD_W-2:0] sh;

    assign wide     = in_is_wide(compress);
    assign slot_idx = wide ? (bitpos >> 3) : (bitpos >> 2);
    assign offset   = wide ? bitpos[2:0] : {1'b0, bitpos[1:0]};
    assign last_off = wide ? 3'(WORD_W - 1) : 3'(NIBBLE_W - 1);
    assign hit      = in_range && (slot_idx == POS_W'(in_slot));

    always_ff @(posedge clk) begin
        if (rst) begin
            sh       <= '0;
            rx_word  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (fall && hit) begin
                sh <= {sh[WORD_W-3:0], din_s};
                if (offset == last_off) begin
                    rx_word  <= wide ? {sh[WORD_W-2:0], din_s}
                                     : {4'b0, sh[NIBBLE_W-2:0], din_s};
                    rx_valid <= 1'b1;
                end
            end
        end
    end

    // R3: a captured word is only ever published on a falling edge
    a_r3_valid_on_fall: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> $past(fall));

endmodule

// File: rtl/tsa_tx.sv
module tsa_tx
    import tsa_pkg::*;
#(
    parameter int POS_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start,
    input  logic [POS_W-1:0]  bitpos,
    input  logic              in_range,
    input  logic              idle,
    input  logic              bypass,
    input  logic              compress,
    input  logic [SLOT_W-1:0] out_slot,
    input  logic [WORD_W-1:0] rx_word,
    input  logic [WORD_W-1:0] tx_word,
    output logic              dout,
    output logic              doe
);
    logic [WORD_W-1:0] hold;
    logic              wide;
    logic [POS_W-1:0]  slot_idx;
    logic [2:0]        offset;
    logic              cur_bit;

    assign wide     = out_is_wide(compress, bypass);
    assign slot_idx = wide ? (bitpos >> 3) : (bitpos >> 2);
    assign offset   = wide ? bitpos[2:0] : {1'b0, bitpos[1:0]};
    assign cur_bit  = wide ? hold[3'(WORD_W - 1) - offset]
                           : hold[3'(NIBBLE_W - 1) - offset];

    always_ff @(posedge clk) begin
        if (rst) begin
            hold <= '0;
        end else if (frame_start) begin
            hold <= bypass ? rx_word : tx_word;
        end
    end

    assign doe  = !idle && in_range && (slot_idx == POS_W'(out_slot));
    assign dout = doe & cur_bit;

endmodule

// File: rtl/tdm_slot_port.sv
module tdm_slot_port
    import tsa_pkg::*;
#(
    parameter int FRAME_MU    = 256,
    parameter int FRAME_A     = 256,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tdm_clk,
    input  logic              tdm_fsync,
    input  logic              tdm_din,
    input  logic              cfg_idle,
    input  logic              cfg_bypass,
    input  logic              cfg_compress,
    input  logic              cfg_mulaw,
    input  logic [1:0]        cfg_alg,
    input  logic [SLOT_W-1:0] cfg_in_slot,
    input  logic [SLOT_W-1:0] cfg_out_slot,
    input  logic [WORD_W-1:0] tx_word,
    output logic              tdm_dout,
    output logic              tdm_doe,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_valid,
    output logic              sig_frame,
    output logic [1:0]        alg_eff
);
    localparam int FRAME_MAX = (FRAME_MU > FRAME_A) ? FRAME_MU : FRAME_A;
    localparam int POS_W     = $clog2(FRAME_MAX + 1);

    logic             rise, fall, fs_s, din_s;
    logic [POS_W-1:0] bitpos;
    logic             in_range, frame_start;
    chan_cfg_t        cfg_in, act;

    assign cfg_in = '{
        idle:     cfg_idle,
        bypass:   cfg_bypass,
        compress: cfg_compress,
        mulaw:    cfg_mulaw,
        alg:      alg_e'(cfg_alg),
        in_slot:  cfg_in_slot,
        out_slot: cfg_out_slot
    };

    tsa_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .tdm_clk(tdm_clk), .tdm_fsync(tdm_fsync),
        .tdm_din(tdm_din), .rise(rise), .fall(fall), .fs_s(fs_s), .din_s(din_s)
    );

    tsa_frame_ctr #(.FRAME_MU(FRAME_MU), .FRAME_A(FRAME_A), .POS_W(POS_W)) u_frame (
        .clk(clk), .rst(rst), .rise(rise), .fs_s(fs_s), .cfg_in(cfg_in),
        .bitpos(bitpos), .in_range(in_range), .frame_start(frame_start),
        .sig_frame(sig_frame), .act(act)
    );

    tsa_rx #(.POS_W(POS_W)) u_rx (
        .clk(clk), .rst(rst), .fall(fall), .din_s(din_s), .bitpos(bitpos),
        .in_range(in_range), .compress(act.compress), .in_slot(act.in_slot),
        .rx_word(rx_word), .rx_valid(rx_valid)
    );

    tsa_tx #(.POS_W(POS_W)) u_tx (
        .clk(clk), .rst(rst), .frame_start(frame_start), .bitpos(bitpos),
        .in_range(in_range), .idle(act.idle), .bypass(act.bypass),
        .compress(act.compress), .out_slot(act.out_slot), .rx_word(rx_word),
        .tx_word(tx_word), .dout(tdm_dout), .doe(tdm_doe)
    );

    assign alg_eff = eff_alg(act.alg, sig_frame);

    // R11: a signalling frame never runs the 32 kbps algorithm
    a_r11_sig_not32: assert property (@(posedge clk) disable iff (rst)
        sig_frame |-> alg_eff != 2'(ALG_R32));

    // R9: nothing is driven once the counter has stopped
    a_r9_no_drive_past_end: assert property (@(posedge clk) disable iff (rst)
        !in_range |-> !tdm_doe);

    // R7: an idled channel keeps the line released
    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        act.idle |-> !tdm_doe);

endmodule

// File: tb/tdm_slot_port_tb.sv
module tdm_slot_port_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tdm_clk = 1'b0, tdm_fsync = 1'b0, tdm_din = 1'b0;
    logic       cfg_idle = 1'b0, cfg_bypass = 1'b0, cfg_compress = 1'b0, cfg_mulaw = 1'b0;
    logic [1:0] cfg_alg = 2'd0;
    logic [5:0] cfg_in_slot = '0, cfg_out_slot = '0;
    logic [7:0] tx_word = '0;
    logic       tdm_dout, tdm_doe, rx_valid, sig_frame;
    logic [7:0] rx_word;
    logic [1:0] alg_eff;

    int n_tests = 0, n_fail = 0, rxv_total = 0;
    logic in_bits [0:319];
    logic obs_oe  [0:319];
    logic obs_out [0:319];

    always #2.5 clk = ~clk;

    tdm_slot_port u_dut (
        .clk(clk), .rst(rst), .tdm_clk(tdm_clk), .tdm_fsync(tdm_fsync), .tdm_din(tdm_din),
        .cfg_idle(cfg_idle), .cfg_bypass(cfg_bypass), .cfg_compress(cfg_compress),
        .cfg_mulaw(cfg_mulaw), .cfg_alg(cfg_alg), .cfg_in_slot(cfg_in_slot),
        .cfg_out_slot(cfg_out_slot), .tx_word(tx_word), .tdm_dout(tdm_dout),
        .tdm_doe(tdm_doe), .rx_word(rx_word), .rx_valid(rx_valid),
        .sig_frame(sig_frame), .alg_eff(alg_eff)
    );

    always @(posedge clk) if (!rst && rx_valid) rxv_total <= rxv_total + 1;

    // {mulaw, compress, bypass, in_slot, out_slot, in_word, tx_word}
    localparam logic [30:0] VEC [6] = '{
        {1'b1, 1'b1, 1'b0, 6'd3,  6'd10, 8'hA5, 8'h0C},  // R3 encode, middle slots
        {1'b0, 1'b1, 1'b0, 6'd31, 6'd63, 8'h3C, 8'h09},  // R3 encode, last slots
        {1'b1, 1'b0, 1'b0, 6'd0,  6'd0,  8'h0B, 8'h96},  // R4 decode, first slots
        {1'b0, 1'b0, 1'b0, 6'd63, 6'd31, 8'h06, 8'h5A},  // R4 decode, last slots
        {1'b1, 1'b1, 1'b1, 6'd5,  6'd7,  8'hC3, 8'hFF},  // R5 wide pass-through
        {1'b0, 1'b0, 1'b1, 6'd12, 6'd50, 8'h0D, 8'h03}   // R5 narrow pass-through
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic bit_period(input logic fs, input logic din, output logic o_oe, output logic o_out);
        tdm_clk = 1'b1;
        @(negedge clk);
        tdm_fsync = fs;
        tdm_din   = din;
        repeat (3) @(negedge clk);
        o_oe  = tdm_doe;
        o_out = tdm_dout;
        tdm_clk = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic run_frame(input bit dbl, input int nbits, input int chg_bit,
                             input logic [5:0] chg_slot, input logic [7:0] chg_tx);
        logic a, b;
        bit_period(1'b1, 1'b0, a, b);
        for (int i = 0; i < nbits; i++) begin
            if (i == chg_bit) begin
                cfg_out_slot = chg_slot;
                tx_word      = chg_tx;
            end
            bit_period((i == 0) && dbl, in_bits[i], a, b);
            obs_oe[i]  = a;
            obs_out[i] = b;
        end
    endtask

    task automatic place_word(input int slot, input int w, input logic [7:0] word);
        for (int i = 0; i < 320; i++) in_bits[i] = 1'b0;
        for (int k = 0; k < w; k++) in_bits[slot * w + k] = word[w - 1 - k];
    endtask

    // Count enabled bits and mismatches against one expected slot over nbits.
    task automatic check_out(input string req, input int slot, input int w,
                             input logic [7:0] word, input int nbits);
        int oes = 0, bad = 0;
        for (int i = 0; i < nbits; i++) begin
            logic e_oe;
            e_oe = (i / w == slot) && (i < 256);
            if (obs_oe[i]) oes++;
            if (obs_oe[i] !== e_oe) bad++;
            else if (e_oe && obs_out[i] !== word[w - 1 - (i % w)]) bad++;
        end
        chk(req, "enabled bit count", oes, (slot * w < 256) ? w : 0);
        chk(req, "slot position/data mismatches", bad, 0);
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int oes;
        logic a, b;
        for (int i = 0; i < 320; i++) in_bits[i] = 1'b0;
        repeat (6) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk("R1", "tdm_doe after reset", tdm_doe, 0);
        chk("R1", "rx_valid after reset", rx_valid, 0);
        chk("R1", "sig_frame after reset", sig_frame, 0);
        chk("R1", "alg_eff after reset", alg_eff, 0);
        cfg_out_slot = 6'd0;
        cfg_compress = 1'b1;
        oes = 0;
        for (int i = 0; i < 20; i++) begin
            bit_period(1'b0, 1'b1, a, b);
            if (a) oes++;
        end
        chk("R1", "drive before first sync", oes, 0);

        // Table walk: R2..R5 slot placement, capture and loopback
        for (int v = 0; v < 6; v++) begin
            logic [30:0] e;
            int iw, ow, rxv0;
            logic [7:0] exp_rx, exp_out;
            e = VEC[v];
            cfg_mulaw    = e[30];
            cfg_compress = e[29];
            cfg_bypass   = e[28];
            cfg_in_slot  = e[27:22];
            cfg_out_slot = e[21:16];
            tx_word      = e[7:0];
            iw = e[29] ? 8 : 4;
            ow = e[28] ? iw : (e[29] ? 4 : 8);
            exp_rx  = (iw == 8) ? e[15:8] : {4'b0, e[11:8]};
            exp_out = e[28] ? exp_rx : e[7:0];
            place_word(e[27:22], iw, e[15:8]);
            rxv0 = rxv_total;
            run_frame(1'b0, 256, -1, 6'd0, 8'd0);
            chk(e[28] ? "R5" : (e[29] ? "R3" : "R4"), "rx_word", rx_word, exp_rx);
            chk("R3", "rx_valid pulses per frame", rxv_total - rxv0, 1);
            for (int i = 0; i < 320; i++) in_bits[i] = 1'b0;
            run_frame(1'b0, 256, -1, 6'd0, 8'd0);
            check_out(e[28] ? "R5" : (e[29] ? "R2/R3" : "R2/R4"), e[21:16], ow, exp_out, 256);
        end
        for (int i = 0; i < 320; i++) in_bits[i] = 1'b0;
        cfg_bypass = 1'b0;

        // R7: idle channel
        cfg_idle = 1'b1; cfg_compress = 1'b1; cfg_out_slot = 6'd2; tx_word = 8'h0F;
        run_frame(1'b0, 256, -1, 6'd0, 8'd0);
        oes = 0;
        for (int i = 0; i < 256; i++) if (obs_oe[i]) oes++;
        chk("R7", "enabled bits while idle", oes, 0);
        cfg_idle = 1'b0;

        // R8: slot 40 exists for 4-bit but not 8-bit output slots
        cfg_compress = 1'b0; cfg_out_slot = 6'd40; tx_word = 8'h81;
        run_frame(1'b0, 256, -1, 6'd0, 8'd0);
        check_out("R8", 40, 8, 8'h81, 256);
        cfg_compress = 1'b1;
        run_frame(1'b0, 256, -1, 6'd0, 8'd0);
        check_out("R8", 40, 4, 8'h01, 256);

        // R9: overlong frame, no wrap of the counter
        cfg_out_slot = 6'd0; tx_word = 8'h0A;
        run_frame(1'b0, 300, -1, 6'd0, 8'd0);
        check_out("R9", 0, 4, 8'h0A, 300);

        // R10/R11: sync width and algorithm override
        cfg_alg = 2'd0;
        run_frame(1'b1, 16, -1, 6'd0, 8'd0);
        chk("R10", "sig_frame on two-clock sync", sig_frame, 1);
        chk("R11", "alg_eff 32k in signalling frame", alg_eff, 1);
        run_frame(1'b0, 16, -1, 6'd0, 8'd0);
        chk("R10", "sig_frame on one-clock sync", sig_frame, 0);
        chk("R11", "alg_eff 32k in normal frame", alg_eff, 0);
        cfg_alg = 2'd2;
        run_frame(1'b1, 16, -1, 6'd0, 8'd0);
        chk("R10", "sig_frame on two-clock sync, 16k", sig_frame, 1);
        chk("R11", "alg_eff 16k in signalling frame", alg_eff, 2);
        cfg_alg = 2'd1;
        run_frame(1'b0, 16, -1, 6'd0, 8'd0);
        chk("R11", "alg_eff 24k in normal frame", alg_eff, 1);

        // R12/R6: mid-frame slot and data change applies next frame
        cfg_out_slot = 6'd10; tx_word = 8'h06;
        run_frame(1'b0, 256, -1, 6'd0, 8'd0);
        run_frame(1'b0, 256, 5, 6'd20, 8'h09);
        check_out("R12/R6", 10, 4, 8'h06, 256);
        run_frame(1'b0, 256, -1, 6'd0, 8'd0);
        check_out("R12", 20, 4, 8'h09, 256);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule